// File: doc/BRIEF.md
# Maskable Event Interrupt Unit for a Memory-Card Host

This block gathers the interrupt sources of a memory-card host controller into one flag register, filters them through a mask register, and drives a single interrupt line toward the system interrupt controller. Single-cycle event pulses from the command engine, the data engine and the attached card latch into sticky flags. The two FIFO service requests are not latched: their flag bits mirror the live request levels.

Software reaches the block through a small register port with two selectable registers, the flag register and the mask register. It clears sticky flags by writing ones to them. It rewrites the mask as a whole. The mask uses blocking polarity: a 1 suppresses a source. Flags stay readable whatever the mask holds, so a driver can poll a source whose interrupt it has disabled.

Top module: `sdx_event_irq`

## Requirements
- R1: After reset every sticky flag reads 0, the mask reads all ones and the interrupt output is 0.
- R2: A one-cycle pulse on a sticky source input sets its flag at the next clock edge, and the flag stays set until software clears it. The flag bit positions are: transfer done at bit 0, programming done at bit 1, command end at bit 2, card interrupt at bit 7.
- R3: A write to the flag register (select 0) clears each sticky flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: When a set pulse and a clearing write reach the same sticky flag in the same cycle, the flag ends up set.
- R5: Bit 5 of the flag register reads the live receive-request level and bit 6 reads the live transmit-request level, in the same cycle. Writes do not change them.
- R6: Flag bits 3 and 4 always read 0, and writes to them have no effect on the flag register.
- R7: A write to the mask register (select 1) replaces the whole mask at the next clock edge, and reading select 1 returns the stored mask.
- R8: A flag reads back correctly while its mask bit is 1.
- R9: The interrupt output equals, one clock later, the OR over all bits of the flags ANDed with the inverted mask.
- R10: A source whose mask bit is 1 never raises the interrupt output, and clearing its mask bit while its flag is set raises the output one clock after the mask update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done_pulse | input | 1 | Data transfer finished event |
| prog_done_pulse | input | 1 | Card programming finished event |
| cmd_end_pulse | input | 1 | Command and response finished event |
| card_int_pulse | input | 1 | Interrupt raised by the card |
| rx_req_lvl | input | 1 | Receive FIFO wants servicing (level) |
| tx_req_lvl | input | 1 | Transmit FIFO wants servicing (level) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 flags, 1 mask |
| reg_wr_data | input | FLAG_W | Write data |
| reg_rd_sel | input | 1 | Read source: 0 flags, 1 mask |
| reg_rd_data | output | FLAG_W | Read data, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a set pulse and a clearing write landing on the same sticky flag in the same clock edge. The bench drives both on the same falling edge, so they are sampled together at the next rising edge. It also tries a mixed write that clears one flag while a different flag is being set. The one-cycle lag of the interrupt output is exercised in both directions: a flag is cleared while the output is still high, and a mask is opened on a flag that is already set. In each case the output is sampled in the cycle before it should change and in the cycle after.

// File: rtl/sdx_event_irq_pkg.sv
package sdx_event_irq_pkg;

   // Flag bit positions; software decodes these, so they are fixed.
   localparam int EV_XFER_DONE = 0;
   localparam int EV_PROG_DONE = 1;
   localparam int EV_CMD_END   = 2;
   localparam int EV_RX_REQ    = 5;
   localparam int EV_TX_REQ    = 6;
   localparam int EV_CARD      = 7;

   localparam int MIN_FLAGS = 8;
   localparam int MAX_FLAGS = 64;

   localparam logic REG_SEL_FLAGS = 1'b0;
   localparam logic REG_SEL_MASK  = 1'b1;

   typedef enum logic [1:0] {
      FK_NONE,
      FK_STICKY,
      FK_LEVEL
   } flag_kind_e;

   function automatic flag_kind_e kind_of(input int idx);
      case (idx)
         EV_XFER_DONE, EV_PROG_DONE, EV_CMD_END, EV_CARD: return FK_STICKY;
         EV_RX_REQ, EV_TX_REQ:                          return FK_LEVEL;
         default:                                       return FK_NONE;
      endcase
   endfunction

   function automatic logic [MAX_FLAGS-1:0] kind_mask(input flag_kind_e k);
      logic [MAX_FLAGS-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_FLAGS; i++) begin
         if (kind_of(i) == k) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sdx_event_irq_flags.sv
module sdx_event_irq_flags
   import sdx_event_irq_pkg::*;
#(
   parameter int FLAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_i,
   input  logic [FLAG_W-1:0] lvl_i,
   input  logic [FLAG_W-1:0] clr_i,
   output logic [FLAG_W-1:0] flags_o
);

   localparam logic [FLAG_W-1:0] STICKY_BITS = FLAG_W'(kind_mask(FK_STICKY));
   localparam logic [FLAG_W-1:0] LEVEL_BITS  = FLAG_W'(kind_mask(FK_LEVEL));

   // Inputs at positions of another kind are deliberately left unconnected.
   logic unused_bits;
   assign unused_bits = ^(set_i & ~STICKY_BITS) ^ ^(clr_i & ~STICKY_BITS)
                      ^ ^(lvl_i & ~LEVEL_BITS);

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (kind_of(i) == FK_STICKY) begin : g_sticky
         logic q;
         // Set has priority over a simultaneous clear.
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i[i] | (q & ~clr_i[i]);
         end
         assign flags_o[i] = q;
      end else if (kind_of(i) == FK_LEVEL) begin : g_level
         assign flags_o[i] = lvl_i[i];
      end else begin : g_none
         assign flags_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/sdx_event_irq_mask.sv
module sdx_event_irq_mask #(
   parameter int              FLAG_W   = 8,
   parameter logic [FLAG_W-1:0] MASK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [FLAG_W-1:0] wd_i,
   output logic [FLAG_W-1:0] mask_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_o <= MASK_RST;
      else if (we_i) mask_o <= wd_i;
   end

endmodule

// File: rtl/sdx_event_irq_out.sv
module sdx_event_irq_out #(
   parameter int FLAG_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic [FLAG_W-1:0] mask_i,
   output logic              irq_o
);

   logic pending;
   assign pending = |(flags_i & ~mask_i);

   if (OUT_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = pending;
   end

endmodule

// File: rtl/sdx_event_irq.sv
module sdx_event_irq
   import sdx_event_irq_pkg::*;
#(
   parameter int                FLAG_W   = 8,
   parameter bit                OUT_REG  = 1'b1,
   parameter logic [FLAG_W-1:0] MASK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_done_pulse,
   input  logic              prog_done_pulse,
   input  logic              cmd_end_pulse,
   input  logic              card_int_pulse,
   input  logic              rx_req_lvl,
   input  logic              tx_req_lvl,
   input  logic              reg_wr_en,
   input  logic              reg_wr_sel,
   input  logic [FLAG_W-1:0] reg_wr_data,
   input  logic              reg_rd_sel,
   output logic [FLAG_W-1:0] reg_rd_data,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   if (FLAG_W < MIN_FLAGS || FLAG_W > MAX_FLAGS) begin : g_bad_width
      $error("sdx_event_irq: FLAG_W must lie in [%0d,%0d]", MIN_FLAGS, MAX_FLAGS);
   end

   logic [FLAG_W-1:0] set_w;
   logic [FLAG_W-1:0] lvl_w;
   logic [FLAG_W-1:0] clr_w;
   logic [FLAG_W-1:0] flags_w;
   logic [FLAG_W-1:0] mask_w;
   logic              mask_we;

   always_comb begin
      set_w               = '0;
      set_w[EV_XFER_DONE] = xfer_done_pulse;
      set_w[EV_PROG_DONE] = prog_done_pulse;
      set_w[EV_CMD_END]   = cmd_end_pulse;
      set_w[EV_CARD]      = card_int_pulse;
      lvl_w               = '0;
      lvl_w[EV_RX_REQ]    = rx_req_lvl;
      lvl_w[EV_TX_REQ]    = tx_req_lvl;
   end

   assign clr_w   = (reg_wr_en && reg_wr_sel == REG_SEL_FLAGS) ? reg_wr_data : '0;
   assign mask_we = reg_wr_en && reg_wr_sel == REG_SEL_MASK;

   sdx_event_irq_flags #(.FLAG_W(FLAG_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_w),
      .lvl_i   (lvl_w),
      .clr_i   (clr_w),
      .flags_o (flags_w)
   );

   sdx_event_irq_mask #(.FLAG_W(FLAG_W), .MASK_RST(MASK_RST)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (mask_we),
      .wd_i   (reg_wr_data),
      .mask_o (mask_w)
   );

   sdx_event_irq_out #(.FLAG_W(FLAG_W), .OUT_REG(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags_w),
      .mask_i  (mask_w),
      .irq_o   (irq_o)
   );

   assign reg_rd_data = (reg_rd_sel == REG_SEL_MASK) ? mask_w : flags_w;

endmodule

// File: rtl/sdx_event_irq_chk.sv
module sdx_event_irq_chk
   import sdx_event_irq_pkg::*;
#(
   parameter int FLAG_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FLAG_W-1:0] set_i,
   input logic [FLAG_W-1:0] clr_i,
   input logic              mask_we_i,
   input logic [FLAG_W-1:0] wr_data_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [FLAG_W-1:0] mask_i,
   input logic              irq_i,
   input logic              rx_i,
   input logic              tx_i
);

   localparam logic [FLAG_W-1:0] STICKY_BITS = FLAG_W'(kind_mask(FK_STICKY));
   localparam logic [FLAG_W-1:0] LEVEL_BITS  = FLAG_W'(kind_mask(FK_LEVEL));

   // R2
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & STICKY_BITS)) |=>
         ((flags_i & $past(set_i & STICKY_BITS)) == $past(set_i & STICKY_BITS)));

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & STICKY_BITS & ~set_i)) |=>
         ((flags_i & $past(clr_i & STICKY_BITS & ~set_i)) == '0));

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & set_i & STICKY_BITS)) |=>
         ((flags_i & $past(clr_i & set_i & STICKY_BITS)) == $past(clr_i & set_i & STICKY_BITS)));

   // R5
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_i[EV_RX_REQ] == rx_i && flags_i[EV_TX_REQ] == tx_i);

   // R6
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_i & ~(STICKY_BITS | LEVEL_BITS)) == '0);

   // R7
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> mask_i == $past(wr_data_i));

   if (OUT_REG) begin : g_irq_reg
      // R9
      irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_i == $past(|(flags_i & ~mask_i)));
   end else begin : g_irq_comb
      // R9
      irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_i == |(flags_i & ~mask_i));
   end

endmodule

bind sdx_event_irq sdx_event_irq_chk #(.FLAG_W(FLAG_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .set_i     (set_w),
   .clr_i     (clr_w),
   .mask_we_i (mask_we),
   .wr_data_i (reg_wr_data),
   .flags_i   (flags_w),
   .mask_i    (mask_w),
   .irq_i     (irq_o),
   .rx_i      (rx_req_lvl),
   .tx_i      (tx_req_lvl)
);

// File: tb/sdx_event_irq_bench.sv
`timescale 1ns/1ps
module sdx_event_irq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer = 1'b0, prog = 1'b0, cmd = 1'b0, card = 1'b0;
   logic       rx = 1'b0, tx = 1'b0;
   logic       we = 1'b0, wsel = 1'b0, rsel = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   sdx_event_irq u_sdx_event_irq (
      .clk             (clk),
      .rst_n           (rst_n),
      .xfer_done_pulse (xfer),
      .prog_done_pulse (prog),
      .cmd_end_pulse   (cmd),
      .card_int_pulse  (card),
      .rx_req_lvl      (rx),
      .tx_req_lvl      (tx),
      .reg_wr_en       (we),
      .reg_wr_sel      (wsel),
      .reg_wr_data     (wd),
      .reg_rd_sel      (rsel),
      .reg_rd_data     (rd),
      .irq_o           (irq)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_reg(input logic sel, output logic [7:0] v);
      rsel = sel;
      #1;
      v = rd;
   endtask

   task automatic check_flags(input string req, input logic [7:0] exp);
      logic [7:0] v;
      read_reg(1'b0, v);
      check(req, v, exp);
   endtask

   task automatic check_irq(input string req, input logic exp);
      check(req, {7'd0, irq}, {7'd0, exp});
   endtask

   task automatic write_reg(input logic sel, input logic [7:0] d);
      we = 1'b1; wsel = sel; wd = d;
      step();
      we = 1'b0; wd = '0;
   endtask

   task automatic pulse(input int which);
      case (which)
         0: xfer = 1'b1;
         1: prog = 1'b1;
         2: cmd  = 1'b1;
         default: card = 1'b1;
      endcase
      step();
      xfer = 1'b0; prog = 1'b0; cmd = 1'b0; card = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      read_reg(1'b1, v);
      check("R1 mask", v, 8'hFF);
      check_flags("R1 flags", 8'h00);
      check_irq("R1 irq", 1'b0);
   endtask

   task automatic t_sticky();
      pulse(0); check_flags("R2 xfer bit0", 8'h01);
      pulse(1); check_flags("R2 prog bit1", 8'h03);
      pulse(2); check_flags("R2 cmd bit2", 8'h07);
      pulse(3); check_flags("R2 card bit7", 8'h87);
      repeat (3) step();
      check_flags("R2 held", 8'h87);
      check_irq("R10 all masked", 1'b0);
   endtask

   task automatic t_clear();
      write_reg(1'b0, 8'h00); check_flags("R3 zero write", 8'h87);
      write_reg(1'b0, 8'h01); check_flags("R3 clear bit0", 8'h86);
      write_reg(1'b0, 8'h84); check_flags("R3 clear bits", 8'h02);
   endtask

   task automatic t_collision();
      we = 1'b1; wsel = 1'b0; wd = 8'h02; prog = 1'b1;
      step();
      we = 1'b0; wd = '0; prog = 1'b0;
      check_flags("R4 same bit", 8'h02);
      we = 1'b1; wsel = 1'b0; wd = 8'h03; xfer = 1'b1;
      step();
      we = 1'b0; wd = '0; xfer = 1'b0;
      check_flags("R4 mixed", 8'h01);
      write_reg(1'b0, 8'hFF);
      check_flags("R3 clear all", 8'h00);
   endtask

   task automatic t_levels();
      rx = 1'b1; check_flags("R5 rx", 8'h20);
      tx = 1'b1; check_flags("R5 rx tx", 8'h60);
      write_reg(1'b0, 8'h60); check_flags("R5 write ignored", 8'h60);
      rx = 1'b0; check_flags("R5 rx drop", 8'h40);
      tx = 1'b0; check_flags("R5 tx drop", 8'h00);
   endtask

   task automatic t_unused();
      pulse(3);
      write_reg(1'b0, 8'h18);
      check_flags("R6 unused bits", 8'h80);
      write_reg(1'b0, 8'h80);
      check_flags("R6 cleanup", 8'h00);
   endtask

   task automatic t_mask_rw();
      logic [7:0] v;
      write_reg(1'b1, 8'hA5); read_reg(1'b1, v); check("R7 mask A5", v, 8'hA5);
      write_reg(1'b1, 8'hFF); read_reg(1'b1, v); check("R7 mask FF", v, 8'hFF);
   endtask

   task automatic t_poll();
      pulse(0);
      check_flags("R8 masked poll", 8'h01);
      step(); step();
      check_irq("R10 masked flag", 1'b0);
      write_reg(1'b0, 8'h01);
   endtask

   task automatic t_irq();
      write_reg(1'b1, 8'hFB);
      pulse(2);
      check_flags("R9 flag up", 8'h04);
      check_irq("R9 before latency", 1'b0);
      step();
      check_irq("R9 raised", 1'b1);
      write_reg(1'b0, 8'h04);
      check_flags("R9 cleared", 8'h00);
      check_irq("R9 lag on clear", 1'b1);
      step();
      check_irq("R9 dropped", 1'b0);
      write_reg(1'b1, 8'hBF);
      tx = 1'b1; step();
      check_irq("R9 level raise", 1'b1);
      tx = 1'b0; step();
      check_irq("R9 level drop", 1'b0);
      write_reg(1'b1, 8'hFF);
      pulse(0); step();
      check_irq("R10 masked source", 1'b0);
      write_reg(1'b1, 8'hFE);
      check_irq("R10 unmask lag", 1'b0);
      step();
      check_irq("R10 unmask raise", 1'b1);
      write_reg(1'b0, 8'h01); step();
      check_irq("R10 cleanup", 1'b0);
      write_reg(1'b1, 8'hFF);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_sticky();
      t_clear();
      t_collision();
      t_levels();
      t_unused();
      t_mask_rw();
      t_poll();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule